// File: doc/BRIEF.md
# User Interrupt Send Sequencer

This block carries out the send-user-interrupt operation for one table index at a time. A start strobe hands it an index. It compares the index with a table-size value and then fetches a 16-byte target entry from memory. It checks the entry and then performs a locked read-modify-write of the 128-bit posted-interrupt descriptor that the entry points at. During that update it posts the requested vector. It also decides whether the target needs a notification. The decision uses the descriptor's suppress flag and its outstanding flag.

When a notification is needed, the block emits one ordinary interprocessor-interrupt request after the memory lock has been released. The destination is either the full 32-bit ID or an 8-bit ID. A mode input selects which. Every operation ends with exactly one single-cycle pulse, either `done` or `gp_fault`. Until that pulse the block ignores further start strobes.

Descriptor layout: bit 0 is outstanding (ON), bit 1 is suppress (SN), bits 23:16 are the notification vector, bits 63:32 are the destination, and bits 127:64 are the 64 posted bits. Entry layout: bit 0 is valid, bits 7:1 are reserved, bits 15:8 are the user vector, and bits 127:64 are the descriptor address.

Top module: `uipi_send_seq`

## Requirements
- R1: If `index` > `tbl_size`, the operation ends with a `gp_fault` pulse and issues no memory request. When `index` == `tbl_size`, the operation goes ahead.
- R2: The entry read address is `tbl_base + (index << 4)`, and it is an unlocked read.
- R3: The operation faults after the entry read if entry bit 0 is 0 or if any of entry bits 7:1 is 1.
- R4: The operation faults after the entry read, with no descriptor access, if the entry vector (bits 15:8) is 64 or larger.
- R5: The descriptor is read with `mem_lock` high, at the address in entry bits 127:64. If descriptor bits 15:2 or 31:24 are nonzero, the operation faults with no write, and `mem_lock` is low in the fault cycle.
- R6: The written-back descriptor equals the one read, with bit 64+vector also set.
- R7: If ON (bit 0) and SN (bit 1) are both 0, the write-back sets ON and one IPI request is issued. Otherwise ON is unchanged and no IPI request is issued.
- R8: The write-back goes to the descriptor address with `mem_lock` high. `mem_lock` is low while `ipi_valid` is high.
- R9: The IPI vector is descriptor bits 23:16. When `x2_mode` is 1 at start, the destination is descriptor bits 63:32. Otherwise it is descriptor bits 47:40, zero-extended.
- R10: `done` and `gp_fault` are one-cycle pulses, and they are mutually exclusive. A start strobe given before that pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (used only when idle) |
| index | input | IDX_W | Target table index |
| tbl_base | input | ADDR_W | Target table base address |
| tbl_size | input | IDX_W | Largest legal index |
| x2_mode | input | 1 | 1 selects 32-bit destination IDs |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Locked-access indication (level) |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 128 | Write data |
| mem_rvalid | input | 1 | Response (read data or write acknowledge) |
| mem_rdata | input | 128 | Read data |
| ipi_valid | output | 1 | IPI request pulse |
| ipi_vector | output | 8 | IPI vector |
| ipi_dest | output | 32 | IPI destination ID |
| done | output | 1 | Successful completion pulse |
| gp_fault | output | 1 | Fault completion pulse |

## Verification
The hardest case to reach is a fault on the descriptor read. In that case the lock must fall even though no write-back is ever issued. The bench produces it by planting descriptors in its memory model with single reserved bits set. It then compares the lock level seen at the fault pulse with the level recorded at the locked read. A second subtle case is a start strobe that arrives during an operation. The bench injects one with an out-of-range index while a legal operation is waiting for memory. It then confirms that only one completion pulse appears and that no extra memory traffic follows.

// File: rtl/uipi_send_seq.sv
module uipi_send_seq #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  index,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  tbl_size,
  input  logic              x2_mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [127:0]      mem_wdata,
  input  logic              mem_rvalid,
  input  logic [127:0]      mem_rdata,
  output logic              ipi_valid,
  output logic [7:0]        ipi_vector,
  output logic [31:0]       ipi_dest,
  output logic              done,
  output logic              gp_fault
);
  localparam int NPOST = 64;
  localparam int PBASE = 128 - NPOST;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ENT, S_WT_ENT, S_RD_DSC, S_WT_DSC,
    S_WR_DSC, S_WT_WR, S_IPI, S_DONE, S_FAULT
  } st_t;

  st_t               st;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              x2_q;
  logic [7:0]        vec_q;
  logic [ADDR_W-1:0] dsc_addr_q;
  logic [127:0]      dsc_q;
  logic              notify_q;

  logic              idle;
  logic              ent_bad;
  logic              dsc_bad;
  logic              want_notify;
  logic [127:0]      dsc_upd;

  assign idle        = (st == S_IDLE);
  assign ent_bad     = !mem_rdata[0] || (mem_rdata[7:1] != 7'd0) || (mem_rdata[15:8] >= 8'(NPOST));
  assign dsc_bad     = (mem_rdata[15:2] != 14'd0) || (mem_rdata[31:24] != 8'd0);
  assign want_notify = !mem_rdata[0] && !mem_rdata[1];

  always_comb begin
    dsc_upd = mem_rdata;
    dsc_upd[PBASE + int'(vec_q[5:0])] = 1'b1;
    if (want_notify) dsc_upd[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx_q      <= '0;
      base_q     <= '0;
      x2_q       <= 1'b0;
      vec_q      <= '0;
      dsc_addr_q <= '0;
      dsc_q      <= '0;
      notify_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          idx_q  <= index;
          base_q <= tbl_base;
          x2_q   <= x2_mode;
          st     <= (index > tbl_size) ? S_FAULT : S_RD_ENT;
        end
        S_RD_ENT: st <= S_WT_ENT;
        S_WT_ENT: if (mem_rvalid) begin
          if (ent_bad) st <= S_FAULT;
          else begin
            vec_q      <= mem_rdata[15:8];
            dsc_addr_q <= mem_rdata[64 +: ADDR_W];
            st         <= S_RD_DSC;
          end
        end
        S_RD_DSC: st <= S_WT_DSC;
        S_WT_DSC: if (mem_rvalid) begin
          if (dsc_bad) st <= S_FAULT;
          else begin
            dsc_q    <= dsc_upd;
            notify_q <= want_notify;
            st       <= S_WR_DSC;
          end
        end
        S_WR_DSC: st <= S_WT_WR;
        S_WT_WR:  if (mem_rvalid) st <= notify_q ? S_IPI : S_DONE;
        S_IPI:    st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_RD_ENT) || (st == S_RD_DSC) || (st == S_WR_DSC);
  assign mem_we    = (st == S_WR_DSC);
  assign mem_lock  = (st == S_RD_DSC) || (st == S_WT_DSC) || (st == S_WR_DSC) || (st == S_WT_WR);
  assign mem_addr  = (st == S_RD_ENT) ? base_q + (ADDR_W'(idx_q) << 4) : dsc_addr_q;
  assign mem_wdata = dsc_q;

  assign ipi_valid  = (st == S_IPI);
  assign ipi_vector = dsc_q[23:16];
  assign ipi_dest   = x2_q ? dsc_q[63:32] : {24'd0, dsc_q[47:40]};
  assign done       = (st == S_DONE);
  assign gp_fault   = (st == S_FAULT);
endmodule

module uipi_send_chk #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle,
  input logic             start,
  input logic [IDX_W-1:0] index,
  input logic [IDX_W-1:0] tbl_size,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_lock,
  input logic             ipi_valid,
  input logic             done,
  input logic             gp_fault
);
  // R1
  oob_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start && (index > tbl_size) |=> gp_fault && !mem_req);
  // R8
  wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && mem_lock);
  // R8
  ipi_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid |-> !mem_lock);
  // R10
  one_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, gp_fault, ipi_valid}));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !gp_fault);
  // R7
  ipi_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid |=> done);
endmodule

bind uipi_send_seq uipi_send_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_uipi_send_seq.sv
module test_uipi_send_seq;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic start = 0, x2_mode = 0;
  logic [63:0] index = 0, tbl_base = 64'h100, tbl_size = 64'd7;
  logic mem_req, mem_we, mem_lock, mem_rvalid = 0;
  logic [63:0] mem_addr;
  logic [127:0] mem_wdata, mem_rdata = 0;
  logic ipi_valid, done, gp_fault;
  logic [7:0] ipi_vector;
  logic [31:0] ipi_dest;

  uipi_send_seq i_uipi_send_seq (.*);

  int n_chk = 0, n_bad = 0;
  logic [127:0] mem [0:255];
  int dly = 0;
  logic [127:0] pend;
  int rd_n, wr_n, ipi_n, done_n, flt_n;
  logic [63:0] rd_addr [0:3];
  logic rd_lock [0:3];
  logic [63:0] wr_addr;
  logic [127:0] wr_data;
  logic wr_lock, ipi_lock, flt_lock;
  logic [7:0] ipi_v;
  logic [31:0] ipi_d;

  task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_rvalid = 0;
    if (dly == 1) begin mem_rvalid = 1; mem_rdata = pend; end
    if (dly > 0) dly--;
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[11:4]] = mem_wdata;
        wr_n++; wr_addr = mem_addr; wr_data = mem_wdata; wr_lock = mem_lock;
        pend = '0;
      end else begin
        if (rd_n < 4) begin rd_addr[rd_n] = mem_addr; rd_lock[rd_n] = mem_lock; end
        rd_n++;
        pend = mem[mem_addr[11:4]];
      end
      dly = 2;
    end
    if (ipi_valid) begin ipi_n++; ipi_v = ipi_vector; ipi_d = ipi_dest; ipi_lock = mem_lock; end
    if (done) done_n++;
    if (gp_fault) begin flt_n++; flt_lock = mem_lock; end
  end

  function automatic logic [127:0] ent(logic [7:0] low, logic [7:0] vec, logic [63:0] a);
    return {a, 48'd0, vec, low};
  endfunction

  function automatic logic [127:0] dsc(logic [31:0] dst, logic [7:0] nv, logic [15:0] lo);
    return {64'd0, dst, 8'd0, nv, lo};
  endfunction

  task automatic run(logic [63:0] idx, logic mode, bit extra_start = 0);
    rd_n = 0; wr_n = 0; ipi_n = 0; done_n = 0; flt_n = 0;
    @(negedge clk);
    index = idx; x2_mode = mode; start = 1;
    @(negedge clk);
    start = 0;
    if (extra_start) begin
      @(negedge clk); index = 64'hFFFF; start = 1;
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 60 && done_n == 0 && flt_n == 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 reset done", done, 0);
    chk("R10 reset fault", gp_fault, 0);
    chk("R8 reset lock", mem_lock, 0);
    chk("R1 reset req", mem_req, 0);
    chk("R7 reset ipi", ipi_valid, 0);
  endtask

  task automatic t_oob;
    run(64'd8, 0);
    chk("R1 fault", flt_n, 1);
    chk("R1 no access", rd_n + wr_n, 0);
    chk("R10 no done", done_n, 0);
  endtask

  task automatic t_notify_xapic;
    mem[23] = ent(8'h01, 8'd5, 64'h800);
    mem[128] = dsc(32'h00AB_CD00, 8'h42, 16'h0000);
    run(64'd7, 0);
    chk("R2 entry addr", rd_addr[0], 64'h170);
    chk("R2 entry unlocked", rd_lock[0], 0);
    chk("R5 desc addr", rd_addr[1], 64'h800);
    chk("R5 desc locked", rd_lock[1], 1);
    chk("R8 wr addr", wr_addr, 64'h800);
    chk("R8 wr locked", wr_lock, 1);
    chk("R6 R7 wr data", wr_data, dsc(32'h00AB_CD00, 8'h42, 16'h0001) | (128'd1 << 69));
    chk("R7 ipi count", ipi_n, 1);
    chk("R9 vector", ipi_v, 8'h42);
    chk("R9 8-bit dest", ipi_d, 32'h0000_00CD);
    chk("R8 lock at ipi", ipi_lock, 0);
    chk("R10 done once", done_n, 1);
  endtask

  task automatic t_on_set;
    mem[17] = ent(8'h01, 8'd0, 64'h810);
    mem[129] = dsc(32'h1234_5678, 8'h10, 16'h0001) | (128'd1 << 100);
    run(64'd1, 1);
    chk("R7 no ipi when ON", ipi_n, 0);
    chk("R6 on set data", wr_data, dsc(32'h1234_5678, 8'h10, 16'h0001) | (128'd1 << 100) | (128'd1 << 64));
    chk("R10 done", done_n, 1);
  endtask

  task automatic t_sn_set;
    mem[18] = ent(8'h01, 8'd9, 64'h820);
    mem[130] = dsc(32'h1, 8'h11, 16'h0002);
    run(64'd2, 0);
    chk("R7 no ipi when SN", ipi_n, 0);
    chk("R7 ON kept 0", wr_data, dsc(32'h1, 8'h11, 16'h0002) | (128'd1 << 73));
  endtask

  task automatic t_bad_entry;
    mem[19] = ent(8'h00, 8'd1, 64'h830);
    run(64'd3, 0);
    chk("R3 invalid fault", flt_n, 1);
    chk("R3 one read", rd_n, 1);
    mem[19] = ent(8'h09, 8'd1, 64'h830);
    run(64'd3, 0);
    chk("R3 reserved fault", flt_n, 1);
    chk("R3 no write", wr_n, 0);
  endtask

  task automatic t_big_vec;
    mem[20] = ent(8'h01, 8'd64, 64'h840);
    mem[132] = dsc(32'h1, 8'h11, 16'h0000);
    run(64'd4, 0);
    chk("R4 fault", flt_n, 1);
    chk("R4 no desc read", rd_n, 1);
  endtask

  task automatic t_bad_dsc;
    mem[21] = ent(8'h01, 8'd3, 64'h850);
    mem[133] = dsc(32'h1, 8'h11, 16'h0020);
    run(64'd5, 0);
    chk("R5 low reserved fault", flt_n, 1);
    chk("R5 no write", wr_n, 0);
    chk("R5 lock released", flt_lock, 0);
    mem[133] = dsc(32'h1, 8'h11, 16'h0000) | (128'd1 << 30);
    run(64'd5, 0);
    chk("R5 high reserved fault", flt_n, 1);
    chk("R5 no write hi", wr_n, 0);
  endtask

  task automatic t_notify_x2;
    mem[22] = ent(8'h01, 8'd63, 64'h860);
    mem[134] = dsc(32'hDEAD_BEEF, 8'hE7, 16'h0000);
    run(64'd6, 1);
    chk("R9 32-bit dest", ipi_d, 32'hDEAD_BEEF);
    chk("R9 vector x2", ipi_v, 8'hE7);
    chk("R6 top bit", wr_data[127], 1);
  endtask

  task automatic t_busy_start;
    mem[16] = ent(8'h01, 8'd2, 64'h870);
    mem[135] = dsc(32'h0, 8'h21, 16'h0001);
    run(64'd0, 0, 1);
    chk("R10 start ignored no fault", flt_n, 0);
    chk("R10 single done", done_n, 1);
    chk("R10 no extra reads", rd_n, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_oob;
    t_notify_xapic;
    t_on_set;
    t_sn_set;
    t_bad_entry;
    t_big_vec;
    t_bad_dsc;
    t_notify_x2;
    t_busy_start;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule